// File: doc/BRIEF.md
# Banked Edge-Message Store with Per-Bus Ports

This block is the message memory of one processing module in a multi-module decoder for low-density parity-check codes. It holds edge messages in a row of identical banks, one bank per interconnect bus. While the module works on check nodes, its own datapath reads and writes every bank in the same cycle. This lets all components of a message arrive together and lets results go back to the banks they came from. While bit nodes are processed, bus `i` of the shared interconnect can read or write bank `i` of this module for another module.

Each bank is a single port. Each cycle it serves either the local requester or its bus, and the bus always wins. When both sides ask for the same bank in the same cycle, the local side sees a stall for that bank only and its request is dropped. A read returns its word two clock edges after the request. The return valid appears on the local lane or on the bus lane of the bank that served it, so the lane position names the bus. A bank address is linear: check-set index times the set size, plus the word offset within the set.

Top module: `mb_msg_store`

## Requirements
- R1: After reset, and for the first cycle after it, `loc_rvalid` and `bus_rvalid` are all zero. `loc_stall` is zero for any bank that has no bus request.
- R2: A granted local read presented before clock edge k has its bit in `loc_rvalid`, and its word on the bank's `loc_rdata` lane, after edge k+1 and not after edge k. A local write stores its word at that address.
- R3: All banks are accessed in the same cycle, each with its own address and data, and never disturb one another.
- R4: A write on bus `i` stores into bank `i`. A later local read of that address returns the written word.
- R5: When bank `i` has both a local and a bus request in the same cycle, the bus request is performed. `loc_stall[i]` is high in that cycle and the local request has no effect: no write takes place and no local valid is returned.
- R6: A conflict on one bank stalls only that bank. Local requests to the other banks in the same cycle complete normally.
- R7: A read on bus `i` raises `bus_rvalid[i]` alone after the second edge, with the stored word on `bus_rdata` lane `i`. No local valid is raised for it.
- R8: Bank addresses are linear, set * 96 + offset, so the default of three sets of 96 words spans 0..287 in a 9-bit address. A write at or above 288 is dropped, and a read there returns zero with its valid.
- R9: The same offset in different sets names different words. Address 101 (set 1, offset 5) and address 5 (set 0, offset 5) keep separate values.
- R10: Reads issued on consecutive cycles to one bank return their words on consecutive cycles, in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loc_req | input | NUM_BANKS | Local access request, one bit per bank |
| loc_we | input | NUM_BANKS | Local request is a write (1) or a read (0) |
| loc_addr | input | NUM_BANKS*9 | Local address per bank, bank i in bits [9i+8:9i] |
| loc_wdata | input | NUM_BANKS*6 | Local write word per bank |
| loc_stall | output | NUM_BANKS | Local request lost to the bus this cycle |
| loc_rvalid | output | NUM_BANKS | Local read data valid, per bank |
| loc_rdata | output | NUM_BANKS*6 | Read word per bank, local lane |
| bus_req | input | NUM_BANKS | Bus i requests bank i |
| bus_we | input | NUM_BANKS | Bus request is a write (1) or a read (0) |
| bus_addr | input | NUM_BANKS*9 | Bus address per bank |
| bus_wdata | input | NUM_BANKS*6 | Bus write word per bank |
| bus_rvalid | output | NUM_BANKS | Bus read data valid; bit i marks bus i |
| bus_rdata | output | NUM_BANKS*6 | Read word per bank, bus lane |

## Verification
The assertions assume that every request input is two-state and already meaningful at the first clock edge after reset. They relate the return valids to grants made exactly two edges earlier. For this reason they count edges since reset and do not look into the reset period. The bench holds all requests at zero during reset and changes inputs only on the falling clock edge, so each request is seen at exactly one rising edge. Conflicts are created on purpose with a bus read and a local write on the same bank, and the bank's contents are then read back through the local port.

// File: rtl/mb_pkg.sv
package mb_pkg;
  // linear bank address from a check-set index and a word offset
  function automatic int unsigned lin_addr(input int unsigned set_idx,
                                           input int unsigned offset,
                                           input int unsigned set_words);
    return set_idx * set_words + offset;
  endfunction

  // an address addresses a stored word only below the bank depth
  function automatic logic addr_ok(input int unsigned addr,
                                   input int unsigned depth);
    return addr < depth;
  endfunction
endpackage

// File: rtl/mb_port_arb.sv
module mb_port_arb #(
  parameter int NB = 20
) (
  input  logic [NB-1:0] loc_req,
  input  logic [NB-1:0] bus_req,
  output logic [NB-1:0] gnt_loc,
  output logic [NB-1:0] gnt_bus,
  output logic [NB-1:0] stall
);
  // bus side has fixed priority on its own bank
  always_comb begin
    gnt_bus = bus_req;
    gnt_loc = loc_req & ~bus_req;
    stall   = loc_req & bus_req;
  end
endmodule

// File: rtl/mb_bank.sv
module mb_bank #(
  parameter int W      = 6,
  parameter int DEPTH  = 288,
  parameter int AW     = 9
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  import mb_pkg::*;

  logic [W-1:0] mem [DEPTH];
  logic         in_range;

  assign in_range = addr_ok(int'(addr), DEPTH);

  // first read stage: array access registered
  always_ff @(posedge clk) begin
    if (en && we && in_range) mem[addr] <= wdata;
    if (en && !we) rdata <= in_range ? mem[addr] : '0;
  end
endmodule

// File: rtl/mb_rd_pipe.sv
module mb_rd_pipe #(
  parameter int NB = 20,
  parameter int W  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] rd_loc_s0,
  input  logic [NB-1:0] rd_bus_s0,
  input  logic [NB*W-1:0] data_s1,
  output logic [NB-1:0] loc_rvalid,
  output logic [NB-1:0] bus_rvalid,
  output logic [NB*W-1:0] rdata
);
  logic [NB-1:0] loc_s1, bus_s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_s1     <= '0;
      bus_s1     <= '0;
      loc_rvalid <= '0;
      bus_rvalid <= '0;
    end else begin
      loc_s1     <= rd_loc_s0;
      bus_s1     <= rd_bus_s0;
      loc_rvalid <= loc_s1;
      bus_rvalid <= bus_s1;
    end
  end

  // second read stage: capture only lanes that carry a read
  for (genvar i = 0; i < NB; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (loc_s1[i] || bus_s1[i]) rdata[i*W +: W] <= data_s1[i*W +: W];
    end
  end
endmodule

// File: rtl/mb_msg_store.sv
module mb_msg_store #(
  parameter int NUM_BANKS = 20,
  parameter int WORD_W    = 6,
  parameter int NUM_SETS  = 3,
  parameter int SET_WORDS = 96,
  localparam int DEPTH    = NUM_SETS * SET_WORDS,
  localparam int ADDR_W   = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_BANKS-1:0]          loc_req,
  input  logic [NUM_BANKS-1:0]          loc_we,
  input  logic [NUM_BANKS*ADDR_W-1:0]   loc_addr,
  input  logic [NUM_BANKS*WORD_W-1:0]   loc_wdata,
  output logic [NUM_BANKS-1:0]          loc_stall,
  output logic [NUM_BANKS-1:0]          loc_rvalid,
  output logic [NUM_BANKS*WORD_W-1:0]   loc_rdata,
  input  logic [NUM_BANKS-1:0]          bus_req,
  input  logic [NUM_BANKS-1:0]          bus_we,
  input  logic [NUM_BANKS*ADDR_W-1:0]   bus_addr,
  input  logic [NUM_BANKS*WORD_W-1:0]   bus_wdata,
  output logic [NUM_BANKS-1:0]          bus_rvalid,
  output logic [NUM_BANKS*WORD_W-1:0]   bus_rdata
);
  // named internal events for the checker
  logic [NUM_BANKS-1:0]        gnt_loc, gnt_bus;
  logic [NUM_BANKS-1:0]        rd_loc_s0, rd_bus_s0;
  logic [NUM_BANKS*WORD_W-1:0] data_s1, rdata_s2;

  mb_port_arb #(.NB(NUM_BANKS)) u_arb (
    .loc_req (loc_req),
    .bus_req (bus_req),
    .gnt_loc (gnt_loc),
    .gnt_bus (gnt_bus),
    .stall   (loc_stall)
  );

  assign rd_loc_s0 = gnt_loc & ~loc_we;
  assign rd_bus_s0 = gnt_bus & ~bus_we;

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    logic              b_en, b_we;
    logic [ADDR_W-1:0] b_addr;
    logic [WORD_W-1:0] b_wdata;

    always_comb begin
      b_en    = gnt_bus[i] | gnt_loc[i];
      b_we    = gnt_bus[i] ? bus_we[i] : loc_we[i];
      b_addr  = gnt_bus[i] ? bus_addr[i*ADDR_W +: ADDR_W]
                           : loc_addr[i*ADDR_W +: ADDR_W];
      b_wdata = gnt_bus[i] ? bus_wdata[i*WORD_W +: WORD_W]
                           : loc_wdata[i*WORD_W +: WORD_W];
    end

    mb_bank #(.W(WORD_W), .DEPTH(DEPTH), .AW(ADDR_W)) u_bank (
      .clk   (clk),
      .en    (b_en),
      .we    (b_we),
      .addr  (b_addr),
      .wdata (b_wdata),
      .rdata (data_s1[i*WORD_W +: WORD_W])
    );
  end

  mb_rd_pipe #(.NB(NUM_BANKS), .W(WORD_W)) u_pipe (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_loc_s0  (rd_loc_s0),
    .rd_bus_s0  (rd_bus_s0),
    .data_s1    (data_s1),
    .loc_rvalid (loc_rvalid),
    .bus_rvalid (bus_rvalid),
    .rdata      (rdata_s2)
  );

  assign loc_rdata = rdata_s2;
  assign bus_rdata = rdata_s2;
endmodule

// File: rtl/mb_msg_store_chk.sv
module mb_msg_store_chk #(
  parameter int NB = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NB-1:0] loc_req,
  input logic [NB-1:0] loc_we,
  input logic [NB-1:0] bus_req,
  input logic [NB-1:0] bus_we,
  input logic [NB-1:0] loc_stall,
  input logic [NB-1:0] loc_rvalid,
  input logic [NB-1:0] bus_rvalid,
  input logic [NB-1:0] gnt_loc,
  input logic [NB-1:0] gnt_bus
);
  logic [1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age <= 2'd1) |-> (loc_rvalid == '0 && bus_rvalid == '0));

  // R2
  loc_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (loc_rvalid == $past(loc_req & ~bus_req & ~loc_we, 2)));

  // R7
  bus_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (bus_rvalid == $past(bus_req & ~bus_we, 2)));

  // R5
  stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((loc_stall & ~loc_req) == '0) && ((loc_stall & ~bus_req) == '0));

  // R5
  grant_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_loc & gnt_bus) == '0);

  // R6
  lane_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_rvalid & bus_rvalid) == '0);
endmodule

bind mb_msg_store mb_msg_store_chk #(.NB(NUM_BANKS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .loc_req    (loc_req),
  .loc_we     (loc_we),
  .bus_req    (bus_req),
  .bus_we     (bus_we),
  .loc_stall  (loc_stall),
  .loc_rvalid (loc_rvalid),
  .bus_rvalid (bus_rvalid),
  .gnt_loc    (gnt_loc),
  .gnt_bus    (gnt_bus)
);

// File: tb/sim_mb_msg_store.sv
module sim_mb_msg_store;
  localparam int NB = 20;
  localparam int W  = 6;
  localparam int AW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NB-1:0]    loc_req = '0, loc_we = '0, bus_req = '0, bus_we = '0;
  logic [NB*AW-1:0] loc_addr = '0, bus_addr = '0;
  logic [NB*W-1:0]  loc_wdata = '0, bus_wdata = '0;
  logic [NB-1:0]    loc_stall, loc_rvalid, bus_rvalid;
  logic [NB*W-1:0]  loc_rdata, bus_rdata;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  mb_msg_store u0 (
    .clk(clk), .rst_n(rst_n),
    .loc_req(loc_req), .loc_we(loc_we), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
    .loc_stall(loc_stall), .loc_rvalid(loc_rvalid), .loc_rdata(loc_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic idle();
    loc_req = '0; loc_we = '0; bus_req = '0; bus_we = '0;
  endtask

  task automatic put_loc(input int b, input bit we, input int a, input int d);
    loc_req[b] = 1'b1; loc_we[b] = we;
    loc_addr[b*AW +: AW] = AW'(a); loc_wdata[b*W +: W] = W'(d);
  endtask

  task automatic put_bus(input int b, input bit we, input int a, input int d);
    bus_req[b] = 1'b1; bus_we[b] = we;
    bus_addr[b*AW +: AW] = AW'(a); bus_wdata[b*W +: W] = W'(d);
  endtask

  function automatic int pat(input int b);
    return (b * 3 + 1) % 64;
  endfunction

  // single local read of one bank, result compared two edges later
  task automatic loc_read(input string req, input int b, input int a, input int exp);
    put_loc(b, 1'b0, a, 0);
    @(negedge clk); idle();
    @(negedge clk);
    chk(req, "local valid", 64'(loc_rvalid), 64'(1) << b);
    chk(req, "local data", 64'(loc_rdata[b*W +: W]), 64'(exp));
  endtask

  task automatic t_reset();
    chk("R1", "loc_rvalid", 64'(loc_rvalid), 0);
    chk("R1", "bus_rvalid", 64'(bus_rvalid), 0);
    chk("R1", "loc_stall", 64'(loc_stall), 0);
  endtask

  task automatic t_parallel();
    for (int b = 0; b < NB; b++) put_loc(b, 1'b1, 7, pat(b));
    @(negedge clk); idle();
    for (int b = 0; b < NB; b++) put_loc(b, 1'b0, 7, 0);
    @(negedge clk); idle();
    chk("R2", "no valid after one edge", 64'(loc_rvalid), 0);
    @(negedge clk);
    chk("R3", "all lanes valid", 64'(loc_rvalid), 64'((1 << NB) - 1));
    begin
      int errs = 0;
      for (int b = 0; b < NB; b++)
        if (loc_rdata[b*W +: W] !== W'(pat(b))) errs++;
      chk("R3", "per-bank words", 64'(errs), 0);
    end
  endtask

  task automatic t_bus();
    put_bus(4, 1'b1, 200, 6'h2A);
    @(negedge clk); idle();
    loc_read("R4", 4, 200, 6'h2A);
    put_bus(9, 1'b0, 7, 0);
    @(negedge clk); idle();
    @(negedge clk);
    chk("R7", "bus valid lane", 64'(bus_rvalid), 64'(1) << 9);
    chk("R7", "no local valid", 64'(loc_rvalid), 0);
    chk("R7", "bus data", 64'(bus_rdata[9*W +: W]), 64'(pat(9)));
  endtask

  task automatic t_conflict();
    put_loc(2, 1'b1, 7, 6'h3F);
    put_bus(2, 1'b0, 7, 0);
    put_loc(3, 1'b1, 7, 6'h11);
    #1;
    chk("R5", "stall only on bank 2", 64'(loc_stall), 64'(1) << 2);
    @(negedge clk); idle();
    @(negedge clk);
    chk("R5", "bus served", 64'(bus_rvalid), 64'(1) << 2);
    chk("R5", "old word to bus", 64'(bus_rdata[2*W +: W]), 64'(pat(2)));
    loc_read("R5", 2, 7, pat(2));
    loc_read("R6", 3, 7, 6'h11);
  endtask

  task automatic t_address();
    put_loc(0, 1'b1, 5, 6'h0A);
    @(negedge clk); idle();
    put_loc(0, 1'b1, mb_pkg::lin_addr(1, 5, 96), 6'h15);
    @(negedge clk); idle();
    put_loc(0, 1'b1, 300, 6'h33);
    @(negedge clk); idle();
    loc_read("R9", 0, 5, 6'h0A);
    loc_read("R9", 0, 101, 6'h15);
    loc_read("R8", 0, 300, 0);
    loc_read("R8", 0, 287, 0);
  endtask

  task automatic t_stream();
    put_loc(0, 1'b0, 5, 0);
    @(negedge clk); put_loc(0, 1'b0, 101, 0);
    @(negedge clk); put_loc(0, 1'b0, 7, 0);
    chk("R10", "first word", 64'(loc_rdata[0 +: W]), 6'h0A);
    @(negedge clk); idle();
    chk("R10", "second word", 64'(loc_rdata[0 +: W]), 6'h15);
    @(negedge clk);
    chk("R10", "third word", 64'(loc_rdata[0 +: W]), 64'(pat(0)));
    chk("R10", "third valid", 64'(loc_rvalid), 1);
  endtask

  // write to 287 first so the R8 read above of 287 is not stale
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    put_loc(0, 1'b1, 287, 0);
    @(negedge clk); idle();
    t_parallel();
    t_bus();
    t_conflict();
    t_address();
    t_stream();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule